// File: doc/BRIEF.md
# Flash Program and Erase Sequencer

This block runs the write side of a small on-chip data flash. It accepts a command through a control register, a target byte address and a 32-bit data word, checks the target against a write-protect map, holds a busy flag for a fixed number of cycles, and then updates the array. Six operations are supported: byte program, word program, page erase, small-sector erase, large-sector erase and whole-array erase. Programming can only turn ones into zeros. Erasing sets every byte to 0xFF. The unlock sequence that opens program/erase mode is outside the block and arrives as the `mode_active` input.

The array is organised as `NUM_PAGES` pages of `PAGE_BYTES` bytes. A small sector is `SSECT_PAGES` pages and a large sector is `LSECT_PAGES` pages. Write protection works on regions one small sector wide: bit r of `wprot` guards region r. A production configuration of 64 pages of 512 bytes, with 2-page and 8-page sectors, gives a 32 KB array with 1 KB and 4 KB sectors. The defaults keep those page ratios but use 32-byte pages, so the model stays small. A read port returns any word of the array combinationally, which lets software verify its updates.

Software follows a fixed sequence. It writes the address and the data. It writes the control register with the enable bit and the command bits. It then sets the latch bit, and in a later write it also sets the high-voltage bit. It polls `busy` until it falls, and finally writes the control register to zero. The sequencer has four states:
- IDLE moves to ARMED (transition *arm*) when mode and enable are present with latch set and high-voltage clear.
- ARMED returns to IDLE (*abort*) if latch, enable or mode drops.
- ARMED moves to BUSY (*launch*) when high-voltage rises on a valid, unprotected command.
- ARMED moves to DONE (*drop*) when high-voltage rises on an invalid or protected command.
- BUSY moves to DONE (*finish*) once the operation's cycle count has elapsed. The array is written on this edge.
- DONE moves to IDLE (*release*) once latch and high-voltage are both clear.

Top module: `flash_pe_sequencer`

## Requirements
- R1: After reset, `busy`, `prot_err` and `cerase_done` are 0 and every array word reads 0xFFFFFFFF.
- R2: An operation starts only while `mode_active` is 1 and control bit 0 (enable) is 1. Otherwise `busy` stays 0 and the array is unchanged.
- R3: An operation starts only when control bit 8 (latch) is set in one write, and control bit 9 (high-voltage) is set in a later write while latch is still set. Setting high-voltage before latch, or setting both in the same write, starts nothing.
- R4: `busy` is high for exactly `PROG_CYC` cycles for a program and `ERASE_CYC` cycles for an erase. It rises on the second clock edge after the register write that sets high-voltage. The array already holds the new contents on the cycle `busy` falls.
- R5: Control bit 2 (program) with bit 6 (byte) writes the old byte AND data[7:0] into the byte lane given by address bits [1:0]. The other three bytes of the word are unchanged.
- R6: Control bit 2 with bit 7 (word) writes the old word AND the full data word at the address aligned down to 4 bytes. If both bit 6 and bit 7 are set, the word operation is performed.
- R7: Control bit 1 (erase) alone sets the 4-byte-aligned... page holding the address to all ones: every word of the page-aligned block containing the address reads 0xFFFFFFFF, and words outside it are untouched.
- R8: Erase with bit 3 sets the aligned small sector to all ones. Erase with bit 4 sets the aligned large sector to all ones. Bit 4 takes priority over bit 3.
- R9: Erase with bit 5 sets the whole array to all ones and sets `cerase_done`. That flag then stays 1 until reset.
- R10: If the target range touches any region whose `wprot` bit is 1, the command is dropped. `busy` stays 0, the array is unchanged and `prot_err` becomes 1. `prot_err` clears when the next command is armed.
- R11: After an operation has run or been dropped, no new operation starts until latch and high-voltage have both been written to 0.
- R12: A command with both program and erase set, or with program set but neither byte nor word, starts nothing, changes nothing and does not set `prot_err`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| mode_active | input | 1 | Program/erase mode unlocked |
| ctl_we | input | 1 | Control register write strobe |
| ctl_wdata | input | 10 | Control register write value |
| adr_we | input | 1 | Address register write strobe |
| adr_wdata | input | log2(NUM_PAGES*PAGE_BYTES) | Target byte address |
| dat_we | input | 1 | Data register write strobe |
| dat_wdata | input | 32 | Program data |
| wprot | input | NUM_PAGES/SSECT_PAGES | Write-protect bit per small-sector region |
| rd_widx | input | log2(NUM_PAGES*PAGE_BYTES/4) | Array read word index |
| rd_data | output | 32 | Array word at `rd_widx` |
| busy | output | 1 | Operation in progress |
| prot_err | output | 1 | Last armed command was dropped by protection |
| cerase_done | output | 1 | Sticky: a whole-array erase has completed |

## Verification
The sequencer's state is visible at the ports in two places: the length of `busy` and the array contents read back as soon as `busy` falls. A state machine stuck in DONE, or one that re-arms without a release, shows up on the very next command as a missing busy pulse. A wrongly decoded range or alignment shows up as a corrupted or untouched word in the full-array comparison made after every operation. A bad protection span shows up immediately as a wrong `prot_err`, together with an array that changed when it should not have.

// File: rtl/fpe_pkg.sv
package fpe_pkg;

    // control register layout
    localparam int CTL_W    = 10;
    localparam int CB_EN    = 0;
    localparam int CMD_LSB  = 1;
    localparam int CMD_MSB  = 7;
    localparam int CB_LATCH = 8;
    localparam int CB_HV    = 9;
    localparam int CMD_W    = CMD_MSB - CMD_LSB + 1;

    // positions inside the command field (control bits 7:1)
    localparam int CM_ERASE = 0;
    localparam int CM_PROG  = 1;
    localparam int CM_SSECT = 2;
    localparam int CM_LSECT = 3;
    localparam int CM_ALL   = 4;
    localparam int CM_BYTE  = 5;
    localparam int CM_WORD  = 6;

    typedef enum logic [2:0] {
        OP_NONE,
        OP_BYTE,
        OP_WORD,
        OP_PAGE,
        OP_SSECT,
        OP_LSECT,
        OP_ALL
    } op_e;

    typedef enum logic [1:0] {
        S_IDLE,
        S_ARMED,
        S_BUSY,
        S_DONE
    } st_e;

endpackage

// File: rtl/fpe_decode.sv
module fpe_decode
    import fpe_pkg::*;
#(
    parameter int PAGE_BYTES  = 32,
    parameter int NUM_PAGES   = 64,
    parameter int SSECT_PAGES = 2,
    parameter int LSECT_PAGES = 8,
    parameter int WA          = 9,
    parameter int NREG        = 32
) (
    input  logic [CMD_W-1:0] cmd,
    input  logic [WA+1:0]    adr,
    input  logic [31:0]      dat,
    input  logic [NREG-1:0]  wprot,
    output op_e              op,
    output logic [WA-1:0]    lo,
    output logic [WA-1:0]    hi,
    output logic [31:0]      pword,
    output logic             is_erase,
    output logic             hit_prot
);

    localparam int WPP   = PAGE_BYTES / 4;
    localparam int NW    = NUM_PAGES * WPP;
    localparam int REG_W = SSECT_PAGES * WPP;
    localparam int RSH   = $clog2(REG_W);

    logic [WA-1:0] widx;
    logic [WA:0]   span;
    logic [WA-1:0] lreg;
    logic [WA-1:0] hreg;

    assign widx = adr[WA+1:2];

    // command decode: erase and program are exclusive, wider sizes win
    always_comb begin
        op = OP_NONE;
        if (cmd[CM_ERASE] && !cmd[CM_PROG]) begin
            if (cmd[CM_ALL])        op = OP_ALL;
            else if (cmd[CM_LSECT]) op = OP_LSECT;
            else if (cmd[CM_SSECT]) op = OP_SSECT;
            else                    op = OP_PAGE;
        end else if (cmd[CM_PROG] && !cmd[CM_ERASE]) begin
            if (cmd[CM_WORD])       op = OP_WORD;
            else if (cmd[CM_BYTE])  op = OP_BYTE;
        end
    end

    assign is_erase = (op == OP_PAGE) || (op == OP_SSECT) ||
                      (op == OP_LSECT) || (op == OP_ALL);

    // operation span in words and aligned range
    always_comb begin
        unique case (op)
            OP_PAGE:  span = (WA+1)'(WPP);
            OP_SSECT: span = (WA+1)'(SSECT_PAGES * WPP);
            OP_LSECT: span = (WA+1)'(LSECT_PAGES * WPP);
            OP_ALL:   span = (WA+1)'(NW);
            default:  span = (WA+1)'(1);
        endcase
        lo = widx & ~WA'(span - 1'b1);
        hi = lo + WA'(span - 1'b1);
    end

    // program pattern: byte mode keeps three lanes at all ones
    always_comb begin
        pword = dat;
        if (op == OP_BYTE) begin
            pword = '1;
            for (int b = 0; b < 4; b++) begin
                if (adr[1:0] == 2'(b)) pword[b*8 +: 8] = dat[7:0];
            end
        end
    end

    // protection: any guarded region inside [lo, hi]
    assign lreg = lo >> RSH;
    assign hreg = hi >> RSH;

    always_comb begin
        hit_prot = 1'b0;
        for (int r = 0; r < NREG; r++) begin
            if (wprot[r] && (r >= int'(lreg)) && (r <= int'(hreg))) hit_prot = 1'b1;
        end
    end

endmodule

// File: rtl/fpe_fsm.sv
module fpe_fsm
    import fpe_pkg::*;
#(
    parameter int WA        = 9,
    parameter int PROG_CYC  = 4,
    parameter int ERASE_CYC = 12
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          mode_active,
    input  logic          en,
    input  logic          latch,
    input  logic          hv,
    input  op_e           op,
    input  logic [WA-1:0] lo,
    input  logic [WA-1:0] hi,
    input  logic [31:0]   pword,
    input  logic          is_erase,
    input  logic          hit_prot,
    output logic          busy,
    output logic          commit,
    output logic [WA-1:0] c_lo,
    output logic [WA-1:0] c_hi,
    output logic [31:0]   c_pword,
    output logic          c_erase,
    output logic          prot_err,
    output logic          cdone
);

    localparam int MAXC = (PROG_CYC > ERASE_CYC) ? PROG_CYC : ERASE_CYC;
    localparam int CW   = $clog2(MAXC + 1);

    st_e           state, nxt;
    logic [CW-1:0] cnt;
    logic          c_all;
    logic          allow;
    logic          last;
    logic          arm;
    logic          launch;
    logic          drop_prot;

    assign allow = mode_active && en;
    assign last  = (cnt == (c_erase ? CW'(ERASE_CYC - 1) : CW'(PROG_CYC - 1)));

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= nxt;
    end

    // next state
    always_comb begin
        nxt = state;
        unique case (state)
            S_IDLE: begin
                if (allow && latch && !hv) nxt = S_ARMED;
            end
            S_ARMED: begin
                if (!allow || !latch)                    nxt = S_IDLE;
                else if (hv && (op == OP_NONE || hit_prot)) nxt = S_DONE;
                else if (hv)                             nxt = S_BUSY;
            end
            S_BUSY: begin
                if (last) nxt = S_DONE;
            end
            S_DONE: begin
                if (!latch && !hv) nxt = S_IDLE;
            end
            default: nxt = S_IDLE;
        endcase
    end

    // outputs and transition strobes
    always_comb begin
        busy      = (state == S_BUSY);
        commit    = busy && last;
        arm       = (state == S_IDLE) && (nxt == S_ARMED);
        launch    = (state == S_ARMED) && (nxt == S_BUSY);
        drop_prot = (state == S_ARMED) && (nxt == S_DONE) && (op != OP_NONE) && hit_prot;
    end

    // captured operation, timer and flags
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt      <= '0;
            c_lo     <= '0;
            c_hi     <= '0;
            c_pword  <= '1;
            c_erase  <= 1'b0;
            c_all    <= 1'b0;
            prot_err <= 1'b0;
            cdone    <= 1'b0;
        end else begin
            if (launch) begin
                cnt     <= '0;
                c_lo    <= lo;
                c_hi    <= hi;
                c_pword <= pword;
                c_erase <= is_erase;
                c_all   <= (op == OP_ALL);
            end else if (busy) begin
                cnt <= cnt + 1'b1;
            end
            if (arm)            prot_err <= 1'b0;
            else if (drop_prot) prot_err <= 1'b1;
            if (commit && c_all) cdone <= 1'b1;
        end
    end

    // R2
    start_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(mode_active && en));

    // R3
    start_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(latch && hv));

    // R10
    perr_no_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(prot_err) |-> (!busy && !$past(busy)));

    // R9
    cdone_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cdone |=> cdone);

    // R4
    timer_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (int'(cnt) < MAXC));

endmodule

// File: rtl/fpe_array.sv
module fpe_array #(
    parameter int WA = 9
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          commit,
    input  logic          c_erase,
    input  logic [WA-1:0] c_lo,
    input  logic [WA-1:0] c_hi,
    input  logic [31:0]   c_pword,
    input  logic [WA-1:0] rd_widx,
    output logic [31:0]   rd_data
);

    localparam int NW = 1 << WA;

    logic [31:0]   mem [NW];
    logic [31:0]   old_w;
    logic [WA-1:0] lo_q;
    logic          pchk_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NW; i++) mem[i] <= '1;
        end else if (commit) begin
            for (int i = 0; i < NW; i++) begin
                if ((WA'(i) >= c_lo) && (WA'(i) <= c_hi))
                    mem[i] <= c_erase ? '1 : (mem[i] & c_pword);
            end
        end
    end

    assign rd_data = mem[rd_widx];

    // shadow of the programmed word for the clear-only check
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            old_w  <= '1;
            lo_q   <= '0;
            pchk_q <= 1'b0;
        end else begin
            old_w  <= mem[c_lo];
            lo_q   <= c_lo;
            pchk_q <= commit && !c_erase;
        end
    end

    // R5
    clear_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pchk_q |-> ((mem[lo_q] & ~old_w) == 32'h0));

    // R7
    array_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !commit |=> ((rd_widx != $past(rd_widx)) || $stable(rd_data)));

endmodule

// File: rtl/flash_pe_sequencer.sv
module flash_pe_sequencer
    import fpe_pkg::*;
#(
    parameter int PAGE_BYTES  = 32,
    parameter int NUM_PAGES   = 64,
    parameter int SSECT_PAGES = 2,
    parameter int LSECT_PAGES = 8,
    parameter int PROG_CYC    = 4,
    parameter int ERASE_CYC   = 12
) (
    input  logic                                    clk,
    input  logic                                    rst_n,
    input  logic                                    mode_active,
    input  logic                                    ctl_we,
    input  logic [9:0]                              ctl_wdata,
    input  logic                                    adr_we,
    input  logic [$clog2(NUM_PAGES*PAGE_BYTES)-1:0] adr_wdata,
    input  logic                                    dat_we,
    input  logic [31:0]                             dat_wdata,
    input  logic [NUM_PAGES/SSECT_PAGES-1:0]        wprot,
    input  logic [$clog2(NUM_PAGES*PAGE_BYTES)-3:0] rd_widx,
    output logic [31:0]                             rd_data,
    output logic                                    busy,
    output logic                                    prot_err,
    output logic                                    cerase_done
);

    localparam int AW   = $clog2(NUM_PAGES * PAGE_BYTES);
    localparam int WA   = AW - 2;
    localparam int NREG = NUM_PAGES / SSECT_PAGES;

    logic [CTL_W-1:0] ctl_q;
    logic [AW-1:0]    adr_q;
    logic [31:0]      dat_q;

    op_e           op;
    logic [WA-1:0] lo, hi, c_lo, c_hi;
    logic [31:0]   pword, c_pword;
    logic          is_erase, hit_prot, commit, c_erase;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q <= '0;
            adr_q <= '0;
            dat_q <= '0;
        end else begin
            if (ctl_we) ctl_q <= ctl_wdata;
            if (adr_we) adr_q <= adr_wdata;
            if (dat_we) dat_q <= dat_wdata;
        end
    end

    fpe_decode #(
        .PAGE_BYTES (PAGE_BYTES),
        .NUM_PAGES  (NUM_PAGES),
        .SSECT_PAGES(SSECT_PAGES),
        .LSECT_PAGES(LSECT_PAGES),
        .WA         (WA),
        .NREG       (NREG)
    ) u_dec (
        .cmd     (ctl_q[CMD_MSB:CMD_LSB]),
        .adr     (adr_q),
        .dat     (dat_q),
        .wprot   (wprot),
        .op      (op),
        .lo      (lo),
        .hi      (hi),
        .pword   (pword),
        .is_erase(is_erase),
        .hit_prot(hit_prot)
    );

    fpe_fsm #(
        .WA       (WA),
        .PROG_CYC (PROG_CYC),
        .ERASE_CYC(ERASE_CYC)
    ) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .mode_active(mode_active),
        .en         (ctl_q[CB_EN]),
        .latch      (ctl_q[CB_LATCH]),
        .hv         (ctl_q[CB_HV]),
        .op         (op),
        .lo         (lo),
        .hi         (hi),
        .pword      (pword),
        .is_erase   (is_erase),
        .hit_prot   (hit_prot),
        .busy       (busy),
        .commit     (commit),
        .c_lo       (c_lo),
        .c_hi       (c_hi),
        .c_pword    (c_pword),
        .c_erase    (c_erase),
        .prot_err   (prot_err),
        .cdone      (cerase_done)
    );

    fpe_array #(
        .WA(WA)
    ) u_arr (
        .clk    (clk),
        .rst_n  (rst_n),
        .commit (commit),
        .c_erase(c_erase),
        .c_lo   (c_lo),
        .c_hi   (c_hi),
        .c_pword(c_pword),
        .rd_widx(rd_widx),
        .rd_data(rd_data)
    );

endmodule

// File: tb/flash_pe_sequencer_test.sv
`timescale 1ns/1ps
module flash_pe_sequencer_test;

    localparam int PB   = 32;
    localparam int NP   = 64;
    localparam int SSP  = 2;
    localparam int LSP  = 8;
    localparam int PC   = 4;
    localparam int EC   = 12;
    localparam int WPP  = PB / 4;
    localparam int NW   = NP * WPP;
    localparam int AW   = $clog2(NP * PB);
    localparam int WA   = AW - 2;
    localparam int NREG = NP / SSP;
    localparam int RWW  = SSP * WPP;

    localparam logic [9:0] C_EN   = 10'h001;
    localparam logic [9:0] C_ERS  = 10'h002;
    localparam logic [9:0] C_PRG  = 10'h004;
    localparam logic [9:0] C_SS   = 10'h008;
    localparam logic [9:0] C_LS   = 10'h010;
    localparam logic [9:0] C_ALL  = 10'h020;
    localparam logic [9:0] C_BYTE = 10'h040;
    localparam logic [9:0] C_WORD = 10'h080;
    localparam logic [9:0] C_LAT  = 10'h100;
    localparam logic [9:0] C_HV   = 10'h200;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            mode_active = 1'b1;
    logic            ctl_we = 1'b0;
    logic [9:0]      ctl_wdata = '0;
    logic            adr_we = 1'b0;
    logic [AW-1:0]   adr_wdata = '0;
    logic            dat_we = 1'b0;
    logic [31:0]     dat_wdata = '0;
    logic [NREG-1:0] wprot = '0;
    logic [WA-1:0]   rd_widx = '0;
    logic [31:0]     rd_data;
    logic            busy, prot_err, cerase_done;

    flash_pe_sequencer #(
        .PAGE_BYTES(PB), .NUM_PAGES(NP), .SSECT_PAGES(SSP), .LSECT_PAGES(LSP),
        .PROG_CYC(PC), .ERASE_CYC(EC)
    ) uut (
        .clk(clk), .rst_n(rst_n), .mode_active(mode_active),
        .ctl_we(ctl_we), .ctl_wdata(ctl_wdata),
        .adr_we(adr_we), .adr_wdata(adr_wdata),
        .dat_we(dat_we), .dat_wdata(dat_wdata),
        .wprot(wprot), .rd_widx(rd_widx), .rd_data(rd_data),
        .busy(busy), .prot_err(prot_err), .cerase_done(cerase_done)
    );

    always #2.5 clk = ~clk;

    int          n_chk = 0;
    int          n_bad = 0;
    logic [31:0] exp_mem [NW];
    bit          cur_perr = 0;
    bit          cur_cdone = 0;

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint expv);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, expv);
        end
    endtask

    task automatic wctl(input logic [9:0] v);
        @(negedge clk);
        ctl_we = 1'b1;
        ctl_wdata = v;
        @(negedge clk);
        ctl_we = 1'b0;
    endtask

    task automatic wregs(input int a, input logic [31:0] d);
        @(negedge clk);
        adr_we = 1'b1;
        adr_wdata = AW'(a);
        dat_we = 1'b1;
        dat_wdata = d;
        @(negedge clk);
        adr_we = 1'b0;
        dat_we = 1'b0;
    endtask

    task automatic count_busy(output int nb);
        nb = 0;
        repeat (EC + 6) begin
            if (busy) nb++;
            @(negedge clk);
        end
    endtask

    task automatic do_op(input logic [9:0] cmd, input int a, input logic [31:0] d,
                         input bit clr, output int nb);
        wregs(a, d);
        wctl(cmd);
        wctl(cmd | C_LAT);
        wctl(cmd | C_LAT | C_HV);
        count_busy(nb);
        if (clr) wctl(10'h000);
    endtask

    // expected outcome of an enabled, correctly ordered command
    task automatic model(input logic [9:0] cmd, input int a, input logic [31:0] d,
                         output int eb);
        int span, w, lo, hi;
        bit ers, prg, hit;
        ers = cmd[1];
        prg = cmd[2];
        eb = 0;
        cur_perr = 0;
        if (ers && !prg) begin
            if (cmd[5])      span = NW;
            else if (cmd[4]) span = LSP * WPP;
            else if (cmd[3]) span = SSP * WPP;
            else             span = WPP;
        end else if (prg && !ers && (cmd[6] || cmd[7])) begin
            span = 1;
        end else begin
            return;
        end
        w  = a / 4;
        lo = (w / span) * span;
        hi = lo + span - 1;
        hit = 0;
        for (int r = lo / RWW; r <= hi / RWW; r++) if (wprot[r]) hit = 1;
        if (hit) begin
            cur_perr = 1;
            return;
        end
        eb = ers ? EC : PC;
        for (int i = lo; i <= hi; i++) begin
            if (ers)         exp_mem[i] = '1;
            else if (cmd[7]) exp_mem[i] = exp_mem[i] & d;
            else             exp_mem[i][(a % 4) * 8 +: 8] = exp_mem[i][(a % 4) * 8 +: 8] & d[7:0];
        end
        if (ers && cmd[5]) cur_cdone = 1;
    endtask

    task automatic cmp_array(input string req);
        int   bad_i;
        logic [31:0] bad_a, bad_e;
        bad_i = -1;
        bad_a = '0;
        bad_e = '0;
        for (int i = 0; i < NW; i++) begin
            rd_widx = WA'(i);
            #0.05;
            if (rd_data !== exp_mem[i] && bad_i < 0) begin
                bad_i = i;
                bad_a = rd_data;
                bad_e = exp_mem[i];
            end
        end
        chk(bad_i < 0, req, $sformatf("array word %0d", bad_i), bad_a, bad_e);
    endtask

    task automatic run_chk(input logic [9:0] cmd, input int a, input logic [31:0] d,
                           input string req);
        int nb, eb;
        do_op(cmd | C_EN, a, d, 1'b1, nb);
        model(cmd, a, d, eb);
        chk(nb == eb, (eb == EC) ? "R4" : ((eb == PC) ? "R4" : req), "busy cycles", nb, eb);
        chk(prot_err == cur_perr, req, "prot_err", prot_err, cur_perr);
        chk(cerase_done == cur_cdone, req, "cerase_done", cerase_done, cur_cdone);
        cmp_array(req);
    endtask

    // an attempt that must not start anything
    task automatic expect_idle(input int nb, input string req);
        chk(nb == 0, req, "busy cycles", nb, 0);
        cmp_array(req);
    endtask

    initial begin
        #(150000 * 5);
        n_bad++;
        $display("FAIL watchdog: actual running expected finished");
        $display("  [TB] %0d tests run, %0d failed", n_chk, n_bad);
        $finish;
    end

    initial begin
        int nb, seed, kind, a;
        logic [9:0] cmd;
        for (int i = 0; i < NW; i++) exp_mem[i] = '1;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk(busy == 1'b0, "R1", "busy", busy, 0);
        chk(prot_err == 1'b0, "R1", "prot_err", prot_err, 0);
        chk(cerase_done == 1'b0, "R1", "cerase_done", cerase_done, 0);
        cmp_array("R1");

        // R5 byte lanes and AND behaviour
        run_chk(C_PRG | C_BYTE, 'h45, 32'h0000_00F0, "R5");
        run_chk(C_PRG | C_BYTE, 'h45, 32'hFFFF_FF3C, "R5");
        run_chk(C_PRG | C_BYTE, 'h44, 32'h0000_0011, "R5");
        run_chk(C_PRG | C_BYTE, 'h47, 32'h0000_00A5, "R5");

        // R6 misaligned word program, word bit wins over byte bit
        run_chk(C_PRG | C_WORD, 'h8E, 32'h1234_5678, "R6");
        run_chk(C_PRG | C_WORD | C_BYTE, 'h91, 32'h0F0F_F0F0, "R6");

        // R7 page erase with neighbours programmed
        run_chk(C_PRG | C_WORD, 'h24, 32'h0000_1111, "R7");
        run_chk(C_PRG | C_WORD, 'h64, 32'h0000_2222, "R7");
        run_chk(C_ERS, 'h4C, 32'h0, "R7");

        // R8 small sector, then large with both bits set
        run_chk(C_PRG | C_WORD, 'h50, 32'h0000_3333, "R8");
        run_chk(C_PRG | C_WORD, 'h70, 32'h0000_4444, "R8");
        run_chk(C_ERS | C_SS, 'h47, 32'h0, "R8");
        run_chk(C_PRG | C_WORD, 'h0F0, 32'h0000_5555, "R8");
        run_chk(C_PRG | C_WORD, 'h1F8, 32'h0000_6666, "R8");
        run_chk(C_ERS | C_SS | C_LS, 'h130, 32'h0, "R8");

        // R2 mode inactive and enable clear
        mode_active = 1'b0;
        do_op(C_EN | C_PRG | C_WORD, 'h10, 32'h0, 1'b1, nb);
        expect_idle(nb, "R2");
        mode_active = 1'b1;
        do_op(C_PRG | C_WORD, 'h10, 32'h0, 1'b1, nb);
        expect_idle(nb, "R2");

        // R3 wrong ordering of latch and high-voltage
        wregs('h14, 32'h0);
        wctl(C_EN | C_PRG | C_WORD | C_HV);
        wctl(C_EN | C_PRG | C_WORD | C_HV | C_LAT);
        count_busy(nb);
        wctl(10'h000);
        expect_idle(nb, "R3");
        wctl(C_EN | C_PRG | C_WORD | C_HV | C_LAT);
        count_busy(nb);
        wctl(10'h000);
        expect_idle(nb, "R3");

        // R11 re-trigger without release
        do_op(C_EN | C_PRG | C_WORD, 'h18, 32'hFFFF_0000, 1'b0, nb);
        model(C_PRG | C_WORD, 'h18, 32'hFFFF_0000, a);
        chk(nb == a, "R11", "first run busy", nb, a);
        wctl(C_EN | C_PRG | C_WORD | C_LAT);
        wctl(C_EN | C_PRG | C_WORD | C_LAT | C_HV);
        count_busy(nb);
        wctl(10'h000);
        expect_idle(nb, "R11");
        run_chk(C_PRG | C_WORD, 'h1C, 32'h00FF_00FF, "R11");

        // R12 invalid combinations
        run_chk(C_ERS | C_PRG | C_WORD, 'h20, 32'h0, "R12");
        run_chk(C_PRG, 'h20, 32'h0, "R12");

        // R10 protection drops and flag clears on next arm
        @(negedge clk);
        wprot = NREG'(1) << 3;
        run_chk(C_PRG | C_WORD, 'hC4, 32'h0, "R10");
        run_chk(C_ERS, 'hA0, 32'h0, "R10");
        run_chk(C_ERS | C_SS, 'hE0, 32'h0, "R10");
        run_chk(C_ERS | C_LS, 'h10, 32'h0, "R10");
        run_chk(C_ERS | C_ALL, 'h0, 32'h0, "R10");

        // R9 whole-array erase and sticky flag
        @(negedge clk);
        wprot = '0;
        run_chk(C_PRG | C_WORD, 'h300, 32'h1357_9BDF, "R9");
        run_chk(C_ERS | C_ALL, 'h123, 32'h0, "R9");
        run_chk(C_PRG | C_BYTE, 'h201, 32'h0000_0042, "R9");
        run_chk(C_ERS, 'h200, 32'h0, "R9");

        // constrained random mix
        seed = int'($urandom(32'h00C0_FFEE));
        for (int k = 0; k < 40; k++) begin
            kind = int'($urandom % 5);
            a = int'($urandom % (NW * 4));
            @(negedge clk);
            wprot = (($urandom % 4) == 0) ? (NREG'(1) << ($urandom % NREG)) : '0;
            case (kind)
                0: cmd = C_PRG | C_BYTE;
                1: cmd = C_PRG | C_WORD;
                2: cmd = C_ERS;
                3: cmd = C_ERS | C_SS;
                default: cmd = C_ERS | C_LS;
            endcase
            run_chk(cmd, a, $urandom, "R10");
        end

        $display("  [TB] %0d tests run, %0d failed", n_chk, n_bad);
        $finish;
    end

endmodule